// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous SRAM with Sleep Control

A single-port synchronous memory. One bidirectional bus carries both write data and read data. Each 36-bit word is split into four 9-bit lanes: 8 data bits and 1 parity bit. The parity bit is stored as given; it is not generated or checked. Every access is sampled at a rising clock edge, together with the address, chip select, write enable and the per-lane write selects.

- **Writes** merge only the enabled lanes into the addressed word.
- **Reads** present the stored word on the bus during the following cycle.

The bus driver is gated so that the block never drives while a write is being presented, whatever the output enable is doing. The driver also turns off at once when the output enable goes high.

A low-power sleep input may change at any time. It passes through a two-stage synchronizer and then a two-cycle settle counter before the sleep state changes. Leaving sleep follows the same path in reverse. From the moment the synchronized request appears until recovery completes:
- accesses are dropped;
- the bus stays released;
- stored words are kept.

Top module: `bwsram`

## Requirements
- R1: A read is accepted at a rising edge when `cs_n`=0, `we_n`=1 and the block is awake. While `oe_n`=0, `dq` then carries the word stored at `addr` for the whole following cycle.
- R2: A write is accepted at a rising edge when `cs_n`=0 and `we_n`=0. At that edge, lane i (`dq[9i+8:9i]`) is stored if and only if `bw_n[i]`=0. Lanes whose select is 1 keep their previous contents.
- R3: A write with `we_n`=0 and all four `bw_n` bits at 1 leaves the addressed word unchanged.
- R4: When `cs_n`=1 at an edge, no access takes place, and `dq` is released during the following cycle.
- R5: While `oe_n`=1, `dq` is released, even if a read is pending.
- R6: Whenever `cs_n`=0 and `we_n`=0 are presented, `dq` is released at once, even with `oe_n`=0 and a read pending from the previous edge.
- R7: `zz` is taken through two flops. `sleeping` rises at the fourth rising edge after `zz` goes high, and not earlier.
- R8: `sleeping` falls at the fourth rising edge after `zz` goes low, and not earlier.
- R9: From the second edge after `zz` rises until `sleeping` falls again, reads and writes are ignored and `dq` is released. Contents written before sleep are readable after recovery.
- R10: After reset, `sleeping`=0 and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low; bit i selects lane i |
| oe_n | input | 1 | Output enable, active low |
| zz | input | 1 | Asynchronous sleep request, active high |
| dq | inout | LANES*LANE_W | Shared data bus, lane i at bits 9i+8:9i |
| sleeping | output | 1 | High while in the sleep state |

## Verification
The results arrive at different times:
- Read data is due in the cycle after the accepting edge.
- Bus release for `oe_n` and for a presented write is combinational.
- The `sleeping` flag moves on the fourth edge after a `zz` change.

The bench drives every input at the falling edge and counts rising edges explicitly. It samples one time unit after the falling edge that follows the edge of interest. For each sleep transition it checks the flag both one edge early, where it must be unchanged, and on the due edge. A released bus is seen through a pull-up on every bit, so it reads as all ones. No stimulus reads back an all-ones word.

// File: rtl/bwsram.sv
module bwsram #(
  parameter int ADDR_W    = 4,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int SLEEP_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    zz,
  inout  wire  [LANES*LANE_W-1:0] dq,
  output logic                    sleeping
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(SLEEP_CYC + 1);

  logic [1:0]       zs;
  logic [CNT_W-1:0] cnt;
  logic             sleep_q;
  logic             rd_q;
  logic [WORD_W-1:0] rd_word;

  wire blocked = zs[1] | sleep_q;
  wire wr_cyc  = ~cs_n & ~we_n;
  wire rd_go   = ~blocked & ~cs_n & we_n;
  wire wr_go   = ~blocked & wr_cyc;
  wire drv     = rd_q & ~oe_n & ~wr_cyc & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zs      <= '0;
      cnt     <= '0;
      sleep_q <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      zs   <= {zs[0], zz};
      rd_q <= rd_go;
      if (zs[1] != sleep_q) begin
        if (cnt == CNT_W'(SLEEP_CYC - 1)) begin
          sleep_q <= zs[1];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_lane;
    always_ff @(posedge clk) begin
      if (wr_go && !bw_n[l]) mem[addr] <= dq[l*LANE_W +: LANE_W];
      if (rd_go) rd_lane <= mem[addr];
    end
    assign rd_word[l*LANE_W +: LANE_W] = rd_lane;
  end

  assign dq       = drv ? rd_word : {WORD_W{1'bz}};
  assign sleeping = sleep_q;

  p_rd_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> !rd_q);
  p_drive_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> $past(!cs_n && we_n));
  p_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(zs[1]) && $past(cnt) == CNT_W'(SLEEP_CYC - 1));
  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_q) |-> !$past(zs[1]) && $past(cnt) == CNT_W'(SLEEP_CYC - 1));
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(SLEEP_CYC));
endmodule

// File: tb/sim_bwsram.sv
module sim_bwsram;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, zz = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [W-1:0] dq_drv = '0;
  logic dq_en = 1'b0;
  logic sleeping;
  wire  [W-1:0] dq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  assign dq = dq_en ? dq_drv : {W{1'bz}};
  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (dq[i]);
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  bwsram u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
             .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .dq(dq), .sleeping(sleeping));

  // {is_read, addr, bw_n, data, expected}
  localparam logic [80:0] VEC [0:9] = '{
    {1'b0, 4'd1, 4'b0000, 36'h123456789, 36'h0},
    {1'b0, 4'd2, 4'b0000, 36'hABCDE0123, 36'h0},
    {1'b1, 4'd1, 4'b1111, 36'h0,         36'h123456789},
    {1'b0, 4'd1, 4'b1110, 36'h0000001FF, 36'h0},
    {1'b0, 4'd2, 4'b0111, 36'hFFFFFFFFF, 36'h0},
    {1'b0, 4'd2, 4'b1111, 36'h000000000, 36'h0},
    {1'b1, 4'd2, 4'b1111, 36'h0,         36'hFFCDE0123},
    {1'b0, 4'd1, 4'b1001, 36'h000000000, 36'h0},
    {1'b1, 4'd1, 4'b1111, 36'h0,         36'h1200001FF},
    {1'b1, 4'd2, 4'b1111, 36'h0,         36'hFFCDE0123}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; bw_n = 4'hF; dq_en = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [3:0] b, input logic [W-1:0] d);
    addr = a; cs_n = 1'b0; we_n = 1'b0; bw_n = b; oe_n = 1'b1;
    dq_drv = d; dq_en = 1'b1;
    tick();
    idle();
  endtask

  task automatic do_read(input logic [3:0] a, input logic oe);
    addr = a; cs_n = 1'b0; we_n = 1'b1; bw_n = 4'hF; oe_n = oe; dq_en = 1'b0;
    tick();
    idle();
    #1;
  endtask

  initial begin
    @(negedge clk);
    #1;
    chk("R10 bus released in reset", dq, {W{1'b1}});
    chk("R10 sleeping low in reset", {35'd0, sleeping}, 36'd0);
    tick();
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][80]) begin
        do_read(VEC[i][79:76], 1'b0);
        chk("R1/R2/R3 read word", dq, VEC[i][35:0]);
        tick();
      end else begin
        do_write(VEC[i][79:76], VEC[i][75:72], VEC[i][71:36]);
      end
    end

    // R5: output enable high releases the bus even with a read pending
    do_read(4'd1, 1'b1);
    chk("R5 oe_n high releases bus", dq, {W{1'b1}});
    oe_n = 1'b0;
    #1;
    chk("R5 oe_n low drives pending read", dq, 36'h1200001FF);
    tick();

    // R4: deselected edge gives no read
    oe_n = 1'b0; addr = 4'd1; cs_n = 1'b1;
    tick();
    #1;
    chk("R4 deselected no drive", dq, {W{1'b1}});

    // R6: write presented right after a read forces release; bw all high (R3)
    do_read(4'd2, 1'b0);
    chk("R6 pre-check read drives", dq, 36'hFFCDE0123);
    addr = 4'd2; cs_n = 1'b0; we_n = 1'b0; bw_n = 4'hF;
    #1;
    chk("R6 write presented forces release", dq, {W{1'b1}});
    tick();
    idle();
    do_read(4'd2, 1'b0);
    chk("R3 no-select write kept word", dq, 36'hFFCDE0123);
    tick();

    // R7: sleep entry timing
    zz = 1'b1;
    repeat (3) tick();
    #1;
    chk("R7 sleeping not yet at edge 3", {35'd0, sleeping}, 36'd0);
    tick();
    #1;
    chk("R7 sleeping at edge 4", {35'd0, sleeping}, 36'd1);

    // R9: accesses during sleep ignored
    do_write(4'd1, 4'b0000, 36'h0F0F0F0F0);
    do_read(4'd1, 1'b0);
    chk("R9 read while asleep released", dq, {W{1'b1}});
    tick();

    // R8: exit timing, with a read during recovery
    zz = 1'b0;
    repeat (3) tick();
    #1;
    chk("R8 still sleeping at edge 3", {35'd0, sleeping}, 36'd1);
    do_read(4'd1, 1'b0);
    chk("R8 awake at edge 4", {35'd0, sleeping}, 36'd0);
    chk("R9 read in recovery ignored", dq, {W{1'b1}});
    tick();
    do_read(4'd1, 1'b0);
    chk("R9 contents preserved over sleep", dq, 36'h1200001FF);
    tick();

    // R2: after wake, single-lane write on lane 2
    do_write(4'd5, 4'b0000, 36'h000000000);
    do_write(4'd5, 4'b1011, 36'h0AAC0000);
    do_read(4'd5, 1'b0);
    chk("R2 lane 2 only", dq, 36'h0AAC0000 & 36'h007FC0000);
    tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule